// File: doc/BRIEF.md
# Scanline Interrupt Down-Counter

This block is the line-counting interrupt source of a cartridge banking controller. The CPU side writes four registers through single-cycle strobes: a reload-value store (with an 8-bit data byte), a counter clear, an interrupt disable/acknowledge and an interrupt enable. A separate single-cycle pulse marks each rising edge of the video chip's address line 12, which happens roughly once per rendered line. Each pulse either reloads the counter or decrements it. When the count lands on zero, the block raises a sticky, active-high interrupt request.

A configuration input picks between the standard counter revision and an alternate one. In the alternate revision, a clear write also arms a pending-clear flag. An interrupt is then raised only when the count actually reaches zero, or when a clear was pending. In the standard revision, a reload value of zero fires on every edge. Edge detection and filtering, address decoding and bank mapping all sit outside this block.

Top module: `scan_irq_top`

## Requirements
- R1: After reset the interrupt output is low, interrupts are disabled, the counter is 0 and the reload value is 0xFF. So with interrupts enabled, the first interrupt needs 256 edges.
- R2: A reload-store strobe captures wrData as the reload value that later reloads use.
- R3: A clear strobe sets the counter to 0. In alternate mode (altMode=1) it also arms the pending-clear flag.
- R4: On an edge pulse the counter loads the reload value if it is 0 or a clear is pending; otherwise it decreases by one.
- R5: The pending-clear flag is dropped on every edge pulse.
- R6: In standard mode (altMode=0), an edge that leaves the counter at 0 while interrupts are enabled sets irq.
- R7: In alternate mode, such an edge sets irq only if the counter was nonzero before the edge or a clear was pending. A reload value of 0 therefore fires once after a clear, not on every edge.
- R8: A disable strobe clears irq and disables interrupts. An enable strobe enables interrupts. If both arrive in one cycle, disable wins.
- R9: irq stays high until a disable strobe or reset. An enable strobe does not clear it.
- R10: When register strobes and an edge pulse share a cycle, the writes take effect first and the edge acts on the updated state.
- R11: While interrupts are disabled, no edge sets irq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| altMode | input | 1 | 1 selects the alternate counter revision |
| wrReload | input | 1 | Reload-value store strobe |
| wrClear | input | 1 | Counter clear strobe |
| wrDisable | input | 1 | Interrupt disable and acknowledge strobe |
| wrEnable | input | 1 | Interrupt enable strobe |
| wrData | input | 8 | Data byte for the reload-value store |
| edgePulse | input | 1 | One-cycle pulse per address-line-12 rising edge |
| irq | output | 1 | Sticky interrupt request, active high |

## Verification
The bench targets four behaviours:
- **Zero reload value in both revisions.** A design that ignores the revision select would keep firing in alternate mode, or fire only once in standard mode.
- **Coincident write and edge.** A design that applies the edge before the write reloads the stale value and misses or delays the interrupt.
- **Acknowledge and re-enable ordering.** A design that clears irq on enable, or lets a disabled counter fire, diverges within a few cycles.
- **Arithmetic sweep.** Sweeps over reload values, pre-clears and a long pseudo-random strobe mix compare irq every cycle against a model written from the requirements.

// File: rtl/scan_irq_pkg.sv
package scan_irq_pkg;
  typedef struct packed {
    logic loadLatch;
    logic zeroCount;
  } wr_strobe_t;

  typedef struct packed {
    logic step;
    logic reloadSel;
  } edge_strobe_t;
endpackage

// File: rtl/scan_irq_dpath.sv
module scan_irq_dpath
  import scan_irq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  wr_strobe_t       wrStb,
  input  edge_strobe_t     edgeStb,
  input  logic [CNT_W-1:0] wrData,
  output logic [CNT_W-1:0] countQ,
  output logic [CNT_W-1:0] latchQ,
  output logic             wrCountZero,
  output logic             nextZero
);
  logic [CNT_W-1:0] latchW;
  logic [CNT_W-1:0] cntW;
  logic [CNT_W-1:0] cntN;

  // register writes land before the edge acts (R10)
  always_comb begin
    latchW      = wrStb.loadLatch ? wrData : latchQ;
    cntW        = wrStb.zeroCount ? '0 : countQ;
    wrCountZero = (cntW == '0);
    cntN        = edgeStb.reloadSel ? latchW : (cntW - 1'b1);
    nextZero    = (cntN == '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      latchQ <= '1;
      countQ <= '0;
    end else begin
      latchQ <= latchW;
      countQ <= edgeStb.step ? cntN : cntW;
    end
  end
endmodule

// File: rtl/scan_irq_ctrl.sv
module scan_irq_ctrl
  import scan_irq_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         altMode,
  input  logic         wrReload,
  input  logic         wrClear,
  input  logic         wrDisable,
  input  logic         wrEnable,
  input  logic         edgePulse,
  input  logic         wrCountZero,
  input  logic         nextZero,
  output wr_strobe_t   wrStb,
  output edge_strobe_t edgeStb,
  output logic         pendQ,
  output logic         enQ,
  output logic         irqQ
);
  logic pendW;
  logic enW;
  logic irqW;
  logic fire;

  always_comb begin
    wrStb.loadLatch   = wrReload;
    wrStb.zeroCount   = wrClear;
    pendW             = pendQ | (altMode & wrClear);
    edgeStb.step      = edgePulse;
    edgeStb.reloadSel = wrCountZero | pendW;
    enW               = wrDisable ? 1'b0 : (wrEnable ? 1'b1 : enQ);
    irqW              = wrDisable ? 1'b0 : irqQ;
    fire              = edgePulse & nextZero & enW &
                        (~altMode | ~wrCountZero | pendW);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pendQ <= 1'b0;
      enQ   <= 1'b0;
      irqQ  <= 1'b0;
    end else begin
      pendQ <= edgePulse ? 1'b0 : pendW;
      enQ   <= enW;
      irqQ  <= irqW | fire;
    end
  end
endmodule

// File: rtl/scan_irq_top.sv
module scan_irq_top
  import scan_irq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             altMode,
  input  logic             wrReload,
  input  logic             wrClear,
  input  logic             wrDisable,
  input  logic             wrEnable,
  input  logic [CNT_W-1:0] wrData,
  input  logic             edgePulse,
  output logic             irq
);
  wr_strobe_t       wrStb;
  edge_strobe_t     edgeStb;
  logic [CNT_W-1:0] countQ;
  logic [CNT_W-1:0] latchQ;
  logic             wrCountZero;
  logic             nextZero;
  logic             pendQ;
  logic             enQ;

  scan_irq_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .altMode(altMode), .wrReload(wrReload),
    .wrClear(wrClear), .wrDisable(wrDisable), .wrEnable(wrEnable),
    .edgePulse(edgePulse), .wrCountZero(wrCountZero), .nextZero(nextZero),
    .wrStb(wrStb), .edgeStb(edgeStb), .pendQ(pendQ), .enQ(enQ), .irqQ(irq)
  );

  scan_irq_dpath #(.CNT_W(CNT_W)) u_dpath (
    .clk(clk), .rst_n(rst_n), .wrStb(wrStb), .edgeStb(edgeStb),
    .wrData(wrData), .countQ(countQ), .latchQ(latchQ),
    .wrCountZero(wrCountZero), .nextZero(nextZero)
  );
endmodule

// File: rtl/scan_irq_chk.sv
module scan_irq_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wrReload,
  input logic             wrClear,
  input logic             wrDisable,
  input logic             wrEnable,
  input logic             edgePulse,
  input logic             irq,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] latch,
  input logic             pend,
  input logic             en
);
  p_ack_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wrDisable |=> !irq);

  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !wrDisable) |=> irq);

  p_rise_on_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq && !edgePulse) |=> !irq);

  p_quiet_disabled_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq && !en && !wrEnable) |=> !irq);

  p_clear_zeroes_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wrClear && !edgePulse) |=> (count == '0));

  p_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (edgePulse && !wrClear && !wrReload && count == '0) |=> (count == $past(latch)));

  p_decrement_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (edgePulse && !wrClear && !pend && count != '0) |=> (count == $past(count) - 1'b1));

  p_pend_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    edgePulse |=> !pend);
endmodule

bind scan_irq_top scan_irq_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wrReload(wrReload), .wrClear(wrClear),
  .wrDisable(wrDisable), .wrEnable(wrEnable), .edgePulse(edgePulse),
  .irq(irq), .count(countQ), .latch(latchQ), .pend(pendQ), .en(enQ)
);

// File: tb/scan_irq_top_test.sv
module scan_irq_top_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       altMode = 1'b0;
  logic       wrReload = 1'b0, wrClear = 1'b0, wrDisable = 1'b0, wrEnable = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic       edgePulse = 1'b0;
  logic       irq;

  int checks = 0;
  int errors = 0;

  // reference state built from the requirements
  logic [7:0] mLatch, mCnt;
  logic       mPend, mEn, mIrq;

  always #10 clk = ~clk;

  scan_irq_top uut (
    .clk(clk), .rst_n(rst_n), .altMode(altMode), .wrReload(wrReload),
    .wrClear(wrClear), .wrDisable(wrDisable), .wrEnable(wrEnable),
    .wrData(wrData), .edgePulse(edgePulse), .irq(irq)
  );

  task automatic check(input string tag, input logic exp);
    checks++;
    if (irq !== exp) begin
      errors++;
      $display("FAIL %s: irq=%0b expected %0b at %0t", tag, irq, exp, $time);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    mLatch = 8'hFF; mCnt = 8'h00; mPend = 1'b0; mEn = 1'b0; mIrq = 1'b0;
  endtask

  // one cycle of stimulus, then the model update, then a compare
  task automatic step(input logic r, input logic c, input logic d, input logic e,
                      input logic [7:0] dat, input logic p, input string tag);
    logic [7:0] old;
    wrReload = r; wrClear = c; wrDisable = d; wrEnable = e;
    wrData = dat; edgePulse = p;
    @(posedge clk);
    if (r) mLatch = dat;
    if (c) mCnt = 8'h00;
    if (altMode && c) mPend = 1'b1;
    if (d) begin mEn = 1'b0; mIrq = 1'b0; end
    else if (e) mEn = 1'b1;
    if (p) begin
      old = mCnt;
      if (mCnt == 8'h00 || mPend) mCnt = mLatch;
      else mCnt = mCnt - 8'd1;
      if (mCnt == 8'h00 && mEn && (!altMode || old != 8'h00 || mPend)) mIrq = 1'b1;
      mPend = 1'b0;
    end
    @(negedge clk);
    wrReload = 1'b0; wrClear = 1'b0; wrDisable = 1'b0; wrEnable = 1'b0;
    edgePulse = 1'b0;
    check(tag, mIrq);
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: irq=%0b expected run to end", irq);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;

    // R1: reset state, then the default reload value 0xFF needs 256 edges
    do_reset();
    check("R1 reset irq", 1'b0);
    step(0, 0, 0, 1, 8'h00, 0, "R8 enable");
    for (int i = 0; i < 255; i++) step(0, 0, 0, 0, 8'h00, 1, "R1 R4 count");
    check("R1 no irq after 255 edges", 1'b0);
    step(0, 0, 0, 0, 8'h00, 1, "R1 R6 irq on 256th edge");
    check("R1 irq after 256 edges", 1'b1);

    // R9: enable strobe does not acknowledge; R8 disable does
    step(0, 0, 0, 1, 8'h00, 0, "R9 re-enable keeps irq");
    check("R9 sticky", 1'b1);
    step(0, 0, 1, 0, 8'h00, 0, "R8 ack");
    check("R8 ack low", 1'b0);

    // R11: disabled counter never fires
    step(1, 0, 0, 0, 8'h00, 0, "R2 store 0");
    for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 8'h00, 1, "R11 disabled edges");
    check("R11 quiet", 1'b0);

    // R6: standard mode with reload 0 fires on every edge
    do_reset();
    altMode = 1'b0;
    step(1, 0, 0, 1, 8'h00, 0, "R2 R8 setup");
    for (int i = 0; i < 3; i++) begin
      step(0, 0, 0, 0, 8'h00, 1, "R6 zero reload fires");
      check("R6 fires each edge", 1'b1);
      step(0, 0, 1, 1, 8'h00, 0, "R8 disable wins over enable");
      check("R8 both strobes", 1'b0);
      step(0, 0, 0, 1, 8'h00, 0, "R8 reenable");
    end

    // R7: alternate mode with reload 0 fires once after a clear
    do_reset();
    altMode = 1'b1;
    step(1, 1, 0, 1, 8'h00, 0, "R3 R7 setup");
    step(0, 0, 0, 0, 8'h00, 1, "R7 pending clear fires");
    check("R7 fire after clear", 1'b1);
    step(0, 0, 1, 0, 8'h00, 0, "R8 ack");
    step(0, 0, 0, 1, 8'h00, 0, "R8 enable");
    step(0, 0, 0, 0, 8'h00, 1, "R5 R7 no refire");
    check("R7 no fire without clear", 1'b0);

    // R10: reload write and edge in one cycle use the new value
    do_reset();
    altMode = 1'b0;
    step(0, 0, 0, 1, 8'h00, 0, "R8 enable");
    step(1, 0, 0, 0, 8'h00, 1, "R10 write then edge");
    check("R10 new reload used", 1'b1);
    step(0, 0, 1, 0, 8'h00, 0, "R8 ack");
    step(1, 0, 0, 1, 8'h02, 0, "R2 store 2");
    step(0, 0, 0, 0, 8'h00, 1, "R4 reload 2");
    step(0, 1, 0, 0, 8'h00, 1, "R10 clear then edge reloads");
    step(0, 0, 0, 0, 8'h00, 1, "R4 dec");
    step(0, 0, 0, 0, 8'h00, 1, "R4 R6 reach zero");
    check("R10 R6 after clear+edge", 1'b1);

    // sweep: modes x reload values x pre-clear
    for (int m = 0; m < 2; m++)
      for (int lat = 0; lat < 6; lat++)
        for (int pc = 0; pc < 2; pc++) begin
          do_reset();
          altMode = m[0];
          step(1, 0, 0, 1, 8'(lat), 0, "R2 sweep setup");
          if (pc != 0) step(0, 1, 0, 0, 8'h00, 0, "R3 sweep clear");
          for (int k = 0; k < 20; k++) begin
            step(0, 0, 0, 0, 8'h00, 1, "R4 R6 R7 sweep");
            if (mIrq) step(0, 0, 1, 1, 8'h00, 0, "R8 sweep ack");
            if (!mEn) step(0, 0, 0, 1, 8'h00, 0, "R8 sweep enable");
          end
        end

    // pseudo-random strobe mix in both modes
    lfsr = 16'hACE1;
    for (int m = 0; m < 2; m++) begin
      do_reset();
      altMode = m[0];
      for (int k = 0; k < 4000; k++) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        step(lfsr[0] & lfsr[1] & lfsr[2], lfsr[3] & lfsr[4] & lfsr[5],
             lfsr[6] & lfsr[7] & lfsr[8], lfsr[9] & lfsr[10],
             {5'b0, lfsr[13:11]}, lfsr[14] | lfsr[15], "R3 R5 R7 R10 random");
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule